// File: doc/BRIEF.md
# Addressable Variable-Tap Shift Register

This block is a one-bit serial delay line with a fixed number of storage stages (16 by default, or 32 or 64 by parameter). On every enabled rising clock edge a new bit enters stage 0 and every stored bit moves one stage higher. A binary tap address picks which stage drives the output. The programmed delay is therefore the tap address plus one cycle.

The tap address can be tied to a constant to build a fixed delay line. It can also be changed at any time to retune the delay while a stream is running. Changing the address never drops or resizes stored data, because every stage keeps shifting whatever tap is being observed. Stage contents are preset at time zero from a parameter word. There is no reset pin. The serial input is a plain bit qualified by a shift enable, so no handshake applies: a bit is taken exactly on the clock edges where the enable is high.

Top module: `vsr_top`

## Requirements
- R1: With shift enable held high and tap address m held constant, a bit presented at an edge appears on the output after that edge plus m further edges, a delay of m+1 cycles (address 0 gives 1 cycle, the top address gives DEPTH cycles).
- R2: On a rising edge with shift enable high, the serial input bit is stored in stage 0 and every stage k above 0 takes the value stage k-1 held before the edge.
- R3: The output always equals the stage whose index is the tap address, read as an unsigned binary number. An address change shows on the output within the same cycle, with no clock edge needed.
- R4: All stages shift on every enabled edge whatever the address is. Moving the address to a higher tap exposes bits that were shifted in while a lower tap was selected.
- R5: The address may change on the fly. Toggling the top address bit while the lower bits are all ones switches the delay between DEPTH/2 and DEPTH cycles mid-stream.
- R6: At time zero, stage i holds bit i of the parameter INIT_WORD, so the left-most hex digit of the word fills the highest stages. The default word is all zeros.
- R7: On a rising edge with shift enable low, no stage changes and the output at a fixed address holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| shift_en | input | 1 | Shift enable; when low, the stages keep their contents |
| ser_in | input | 1 | Serial data bit written into stage 0 |
| tap_sel | input | ADDR_W ($clog2(DEPTH)) | Binary index of the stage driven to the output |
| tap_out | output | 1 | Contents of the selected stage |

## Verification
The hardest case to reach is a tap that reaches back past everything shifted in so far, so that the power-on contents and live data must meet at the right stage boundary. It is just as hard to show that stages not being observed keep shifting. The bench reaches both cases by sweeping every tap address between each pair of clock edges, while runs of held enables, fixed addresses, the 7/15 toggle and random enables and addresses move the history through each boundary. The expected bit for any address is worked out from the count of accepted bits and the initial word.

// File: rtl/vsr_pkg.sv
`timescale 1ns/100ps
package vsr_pkg;
  // Width of the tap address for a given stage count.
  function automatic int unsigned vsr_addr_width(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction

  // Stage counts the block is meant to be built with.
  function automatic bit vsr_depth_ok(input int unsigned depth);
    return (depth == 16) || (depth == 32) || (depth == 64);
  endfunction
endpackage

// File: rtl/vsr_stage_chain.sv
`timescale 1ns/100ps
module vsr_stage_chain #(
  parameter int unsigned DEPTH = 16,
  parameter logic [DEPTH-1:0] INIT_WORD = '0
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [DEPTH-1:0] stages
);
  // Power-on contents come from the parameter; there is no reset.
  logic [DEPTH-1:0] chain_q = INIT_WORD;

  always_ff @(posedge clk) begin
    if (shift_en) begin
      chain_q <= {chain_q[DEPTH-2:0], ser_in};
    end
  end

  assign stages = chain_q;
endmodule

// File: rtl/vsr_tap_select.sv
`timescale 1ns/100ps
module vsr_tap_select #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic [DEPTH-1:0]  stages,
  input  logic [ADDR_W-1:0] sel,
  output logic              bit_o
);
  // Purely combinational read of one stage.
  always_comb begin
    bit_o = stages[sel];
  end
endmodule

// File: rtl/vsr_top.sv
`timescale 1ns/100ps
module vsr_top #(
  parameter int unsigned DEPTH = 16,
  parameter logic [DEPTH-1:0] INIT_WORD = '0,
  localparam int unsigned ADDR_W = vsr_pkg::vsr_addr_width(DEPTH)
) (
  input  logic              clk,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic [ADDR_W-1:0] tap_sel,
  output logic              tap_out
);
  logic [DEPTH-1:0] stage_bits;

  generate
    if (vsr_pkg::vsr_depth_ok(DEPTH)) begin : g_chain
      vsr_stage_chain #(
        .DEPTH    (DEPTH),
        .INIT_WORD(INIT_WORD)
      ) u_chain (
        .clk     (clk),
        .shift_en(shift_en),
        .ser_in  (ser_in),
        .stages  (stage_bits)
      );
    end else begin : g_bad_depth
      // Unsupported stage count: the storage is left out.
      assign stage_bits = '0;
    end
  endgenerate

  vsr_tap_select #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) u_tap (
    .stages(stage_bits),
    .sel   (tap_sel),
    .bit_o (tap_out)
  );
endmodule

// File: rtl/vsr_checker.sv
`timescale 1ns/100ps
module vsr_checker #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              shift_en,
  input logic              ser_in,
  input logic [ADDR_W-1:0] tap_sel,
  input logic              tap_out,
  input logic [DEPTH-1:0]  stage_bits
);
  // No reset exists: properties are armed after two edges of history.
  logic [1:0] warm_q = 2'd0;
  logic       armed;

  always_ff @(posedge clk) begin
    if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end
  assign armed = (warm_q >= 2'd2);

  // R2: at tap 0 the output after an enabled edge is the bit taken in.
  p_stage0_load_r2: assert property (@(posedge clk) disable iff (!armed)
    ($past(shift_en) && ($past(tap_sel) == '0) && (tap_sel == '0))
      |-> (tap_out == $past(ser_in)));

  // R3: one tap higher after an enabled edge shows what the lower tap showed.
  p_tap_step_r3: assert property (@(posedge clk) disable iff (!armed)
    ($past(shift_en) && (tap_sel != '0) &&
     (tap_sel == ADDR_W'($past(tap_sel) + 1'b1)))
      |-> (tap_out == $past(tap_out)));

  // R7: disabled edge with a steady address keeps the output.
  p_hold_out_r7: assert property (@(posedge clk) disable iff (!armed)
    (!$past(shift_en) && (tap_sel == $past(tap_sel)))
      |-> (tap_out == $past(tap_out)));

  // R7: disabled edge leaves every stage as it was.
  p_frozen_stages_r7: assert property (@(posedge clk) disable iff (!armed)
    !$past(shift_en) |-> $stable(stage_bits));

  // R4: the top stage after an enabled edge is the old next-to-top stage.
  p_no_discard_r4: assert property (@(posedge clk) disable iff (!armed)
    $past(shift_en) |-> (stage_bits[DEPTH-1] == $past(stage_bits[DEPTH-2])));
endmodule

bind vsr_top vsr_checker #(
  .DEPTH (DEPTH),
  .ADDR_W(ADDR_W)
) u_vsr_checker (
  .clk       (clk),
  .shift_en  (shift_en),
  .ser_in    (ser_in),
  .tap_sel   (tap_sel),
  .tap_out   (tap_out),
  .stage_bits(stage_bits)
);

// File: tb/vsr_top_test.sv
`timescale 1ns/100ps
module vsr_top_test;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW = 4;
  localparam logic [DEPTH-1:0] INIT = 16'hA5C3;

  logic          clk = 1'b0;
  logic          shift_en = 1'b0;
  logic          ser_in = 1'b0;
  logic [AW-1:0] tap_sel = '0;
  logic          tap_out;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  bit  hist[$];

  vsr_top #(.DEPTH(DEPTH), .INIT_WORD(INIT)) uut (
    .clk(clk), .shift_en(shift_en), .ser_in(ser_in),
    .tap_sel(tap_sel), .tap_out(tap_out)
  );

  always #2.5 clk = ~clk;

  // Expected stage content: newest accepted bits first, then the init word.
  function automatic logic expect_bit(input int a);
    int n = hist.size();
    if (n > a) return hist[n-1-a];
    return INIT[a-n];
  endfunction

  task automatic sweep(input string tag, input logic [AW-1:0] home);
    for (int a = 0; a < DEPTH; a++) begin
      logic e;
      tap_sel = AW'(a);
      #0.1;
      e = expect_bit(a);
      checks++;
      if (tap_out !== e) begin
        failures++;
        $display("FAIL %s addr=%0d actual=%b expected=%b", tag, a, tap_out, e);
      end
    end
    tap_sel = home;
  endtask

  task automatic step(input string tag, input logic [AW-1:0] a,
                      input logic c, input logic d);
    @(negedge clk);
    sweep(tag, a);
    shift_en = c;
    ser_in   = d;
    tap_sel  = a;
    @(posedge clk);
    if (c) hist.push_back(d);
  endtask

  initial begin
    #0.2;
    sweep("R6 init", '0);                    // R6: contents before any edge
    for (int i = 0; i < 20; i++)             // R7: enable low, init kept
      step("R7 hold", AW'(i), 1'b0, 1'($urandom));
    for (int m = 0; m < DEPTH; m++)          // R1/R2: fixed-tap delay lines
      for (int i = 0; i < 40; i++)
        step("R1 fixed", AW'(m), 1'b1, 1'($urandom));
    for (int i = 0; i < 60; i++)             // R5: 7 <-> 15 toggle
      step("R5 toggle", ((i / 5) % 2 == 0) ? 4'd7 : 4'd15, 1'b1, 1'($urandom));
    for (int i = 0; i < 30; i++)             // R4: run at tap 0 ...
      step("R4 low", 4'd0, 1'b1, 1'($urandom));
    for (int i = 0; i < 3; i++)              // ... then look far back
      step("R4 high", 4'd15, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++)            // R3/R7: random taps and enables
      step("R3 random", AW'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    sweep("R3 final", '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule